// File: doc/BRIEF.md
# AAL5 IP-over-ATM Cell Segmenter

The block turns one IP packet into a run of 53-byte ATM cells. The packet comes in one byte at a time on a valid/ready stream. The first byte carries a start marker and the last byte an end marker. The circuit number (an 8-bit path id and a 16-bit channel id) and one user byte are sampled together with the start byte. The block puts the classical-IP LLC/SNAP prefix in front of the packet. It then adds zero padding and an 8-byte AAL5 trailer, so that the protocol data unit fills a whole number of 48-byte cell payloads. A CRC-32 over the whole unit closes the trailer.

Cells leave as a byte stream. A flag marks the first header byte of each cell, and the 53 bytes of a cell are emitted on consecutive cycles. Each cell is filled completely before its header is sent, because the header must already say whether the cell is the last one of the unit. The cell count therefore grows in steps with the packet length: one cell up to 32 IP bytes, two cells up to 80 bytes, and 32 cells for 1500 bytes.

Top module: `aal5_seg`

## Requirements
- R1: The first 8 payload bytes of the first cell are AA, AA, 03, 00, 00, 00, 08, 00, in that order, followed by the IP packet bytes in arrival order.
- R2: Every cell is 53 bytes (5 header bytes, then 48 payload bytes) emitted on 53 consecutive cycles with out_valid high. out_cell_start is high only on the first header byte.
- R3: The first four header bytes, most significant bit first, hold the generic flow control nibble as 0, then the 8-bit path id, then the 16-bit channel id, then a 3-bit payload type, then a loss-priority bit of 0. The upper two payload-type bits are 0.
- R4: The lowest payload-type bit (bit 1 of header byte 3) is 1 on the last cell of a unit and 0 on every other cell.
- R5: Header byte 4 is the CRC-8 (polynomial x^8+x^2+x+1, initial value 0, MSB first) of header bytes 0 to 3, XORed with 55h.
- R6: Between the packet and the trailer, 0 to 47 zero bytes are inserted so that the unit length is a multiple of 48. The cell count is ceil((L+16)/48) for an IP packet of L bytes.
- R7: The last 8 payload bytes of the last cell are the user byte, a zero byte, a 16-bit big-endian length, and the CRC. The length equals L+8, counting the prefix and the packet but not the padding or the trailer.
- R8: The trailer's last 4 bytes are, big-endian, the complement of a CRC-32 (polynomial 04C11DB7h, initial all ones, MSB-first per byte) taken over every unit byte before them.
- R9: in_ready is low while the prefix, padding or trailer is being produced and while a cell is being emitted. out_valid is low in the cycle after any cycle with in_ready high.
- R10: When idle, a byte offered without the start marker is accepted (in_ready high) and dropped, and it produces no output.
- R11: After reset, out_valid and out_cell_start are low, and the block is idle.
- R12: Path id, channel id and user byte are taken only with the start byte. Later changes of these inputs during the packet do not alter the cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Packet byte |
| in_sop | input | 1 | First byte of packet |
| in_eop | input | 1 | Last byte of packet |
| in_vpi | input | 8 | Path id, sampled with the start byte |
| in_vci | input | 16 | Channel id, sampled with the start byte |
| in_uu | input | 8 | User byte for the trailer, sampled with the start byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Cell byte |
| out_cell_start | output | 1 | First header byte of a cell |

## Verification
A fill counter that is off by one shifts every later payload byte. The next cell's data then fails to line up within 48 cycles, and the CRC at the end of the unit is also wrong. A corrupted CRC or length register shows only in the final 8 bytes of the last cell, so every packet is checked all the way to its trailer. A wrong pad decision changes the number of cells and moves the end-of-unit bit to a different cell. Both show up at the first header byte where the expected and emitted streams diverge. A state that leaves in_ready high during emission shows one cycle later as input accepted while out_valid is high.

// File: rtl/aal5_pkg.sv
package aal5_pkg;
  localparam int CELL_PAY   = 48;
  localparam int HDR_BYTES  = 5;
  localparam int CELL_BYTES = CELL_PAY + HDR_BYTES;
  localparam int TRL_BYTES  = 8;
  localparam int SNAP_BYTES = 8;
  localparam int LEN_W      = 16;
  localparam int HDR_W      = 8 * (HDR_BYTES - 1);
  localparam logic [31:0] CRC32_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC32_INIT = 32'hFFFF_FFFF;
  localparam logic [7:0]  HEC_POLY   = 8'h07;
  localparam logic [7:0]  HEC_COSET  = 8'h55;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SNAP, ST_DATA, ST_PAD, ST_TRL, ST_SEND
  } seg_st_e;

  // classical-IP prefix; position matters, it is decoded by the receiver
  function automatic logic [7:0] snap_byte(input logic [2:0] idx);
    case (idx)
      3'd0, 3'd1: snap_byte = 8'hAA;
      3'd2:       snap_byte = 8'h03;
      3'd6:       snap_byte = 8'h08;
      default:    snap_byte = 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC32_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[7] ^ d[i]) r = {r[6:0], 1'b0} ^ HEC_POLY;
      else             r = {r[6:0], 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/aal5_crc32_byte.sv
module aal5_crc32_byte
  import aal5_pkg::*;
(
  input  logic [31:0] crc_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_o
);
  always_comb crc_o = crc32_step(crc_i, data_i);
endmodule

// File: rtl/aal5_hec_gen.sv
module aal5_hec_gen
  import aal5_pkg::*;
(
  input  logic [HDR_W-1:0] hdr_i,
  output logic [7:0]       hec_o
);
  always_comb begin
    logic [7:0] acc;
    acc = '0;
    for (int b = 0; b < HDR_BYTES - 1; b++)
      acc = crc8_step(acc, hdr_i[HDR_W-1-8*b -: 8]);
    hec_o = acc ^ HEC_COSET;
  end
endmodule

// File: rtl/aal5_cell_buf.sv
module aal5_cell_buf #(
  parameter int DEPTH = 48,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/aal5_seg.sv
module aal5_seg
  import aal5_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic [7:0]  in_vpi,
  input  logic [15:0] in_vci,
  input  logic [7:0]  in_uu,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_cell_start
);
  localparam int CNT_W  = $clog2(CELL_PAY + 1);
  localparam int SND_W  = $clog2(CELL_BYTES);
  localparam int TIX_W  = $clog2(TRL_BYTES);
  localparam int BUF_AW = $clog2(CELL_PAY);
  localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(CELL_PAY - 1);
  localparam logic [CNT_W-1:0] PAD_STOP  = CNT_W'(CELL_PAY - TRL_BYTES);
  localparam logic [CNT_W-1:0] SNAP_LAST = CNT_W'(SNAP_BYTES - 1);
  localparam logic [SND_W-1:0] SND_LAST  = SND_W'(CELL_BYTES - 1);
  localparam logic [SND_W-1:0] SND_PAY0  = SND_W'(HDR_BYTES);
  localparam logic [TIX_W-1:0] TIX_LAST  = TIX_W'(TRL_BYTES - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  seg_st_e            st_q, st_d, ret_q, ret_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [SND_W-1:0]   snd_q, snd_d;
  logic [TIX_W-1:0]   tix_q, tix_d;
  logic [LEN_W-1:0]   len_q, len_d;
  logic [31:0]        crc_q, crc_d, crc_nxt, crc_fin;
  logic [7:0]         vpi_q, vpi_d, uu_q, uu_d;
  logic [15:0]        vci_q, vci_d;
  logic               last_q, last_d;
  logic               ov_q, ov_d, os_q, os_d;
  logic [7:0]         od_q, od_d;
  logic               wr_en, crc_en, rdy_w;
  logic [7:0]         wr_byte, trl_byte, snd_byte, rd_byte, hec;
  logic [HDR_W-1:0]   hdr_w;
  logic [BUF_AW-1:0]  rd_addr;

  aal5_crc32_byte u_crc (.crc_i(crc_q), .data_i(wr_byte), .crc_o(crc_nxt));

  aal5_cell_buf #(.DEPTH(CELL_PAY), .AW(BUF_AW)) u_buf (
    .clk(clk), .we(wr_en), .waddr(BUF_AW'(cnt_q)), .wdata(wr_byte),
    .raddr(rd_addr), .rdata(rd_byte)
  );

  assign hdr_w = {4'h0, vpi_q, vci_q, 2'b00, last_q, 1'b0};
  aal5_hec_gen u_hec (.hdr_i(hdr_w), .hec_o(hec));

  assign crc_fin = ~crc_q;
  assign rd_addr = (snd_q >= SND_PAY0) ? BUF_AW'(snd_q - SND_PAY0) : '0;

  always_comb begin
    case (tix_q)
      3'd0:    trl_byte = uu_q;
      3'd1:    trl_byte = 8'h00;
      3'd2:    trl_byte = len_q[15:8];
      3'd3:    trl_byte = len_q[7:0];
      3'd4:    trl_byte = crc_fin[31:24];
      3'd5:    trl_byte = crc_fin[23:16];
      3'd6:    trl_byte = crc_fin[15:8];
      default: trl_byte = crc_fin[7:0];
    endcase
    case (snd_q)
      6'd0:    snd_byte = hdr_w[31:24];
      6'd1:    snd_byte = hdr_w[23:16];
      6'd2:    snd_byte = hdr_w[15:8];
      6'd3:    snd_byte = hdr_w[7:0];
      6'd4:    snd_byte = hec;
      default: snd_byte = rd_byte;
    endcase
  end

  // next-state logic
  always_comb begin
    seg_st_e nxt;
    st_d = st_q;   ret_d = ret_q;  cnt_d = cnt_q;  snd_d = snd_q;
    tix_d = tix_q; len_d = len_q;  crc_d = crc_q;  last_d = last_q;
    vpi_d = vpi_q; vci_d = vci_q;  uu_d = uu_q;
    wr_en = 1'b0;  wr_byte = '0;   crc_en = 1'b0;  rdy_w = 1'b0;
    nxt = ST_DATA;
    unique case (st_q)
      ST_IDLE: begin
        rdy_w = !in_sop;
        if (in_valid && in_sop) begin
          vpi_d = in_vpi; vci_d = in_vci; uu_d = in_uu;
          crc_d = CRC32_INIT; len_d = '0; cnt_d = '0;
          st_d = ST_SNAP;
        end
      end
      ST_SNAP: begin
        wr_en = 1'b1; wr_byte = snap_byte(cnt_q[2:0]); crc_en = 1'b1;
        cnt_d = cnt_q + 1'b1; len_d = len_q + 1'b1;
        if (cnt_q == SNAP_LAST) st_d = ST_DATA;
      end
      ST_DATA: begin
        rdy_w = 1'b1;
        if (in_valid) begin
          wr_en = 1'b1; wr_byte = in_data; crc_en = 1'b1;
          cnt_d = cnt_q + 1'b1; len_d = len_q + 1'b1;
          nxt = in_eop ? ST_PAD : ST_DATA;
          if (cnt_q == CNT_FULL) begin
            st_d = ST_SEND; ret_d = nxt; last_d = 1'b0; snd_d = '0;
          end else begin
            st_d = nxt;
          end
        end
      end
      ST_PAD: begin
        if (cnt_q == PAD_STOP) begin
          st_d = ST_TRL; tix_d = '0;
        end else begin
          wr_en = 1'b1; crc_en = 1'b1; cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_FULL) begin
            st_d = ST_SEND; ret_d = ST_PAD; last_d = 1'b0; snd_d = '0;
          end
        end
      end
      ST_TRL: begin
        wr_en = 1'b1; wr_byte = trl_byte; crc_en = !tix_q[2];
        cnt_d = cnt_q + 1'b1; tix_d = tix_q + 1'b1;
        if (tix_q == TIX_LAST) begin
          st_d = ST_SEND; ret_d = ST_IDLE; last_d = 1'b1; snd_d = '0;
        end
      end
      ST_SEND: begin
        snd_d = snd_q + 1'b1;
        if (snd_q == SND_LAST) begin
          st_d = ret_q; cnt_d = '0; snd_d = '0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (crc_en) crc_d = crc_nxt;
    ov_d = (st_q == ST_SEND);
    os_d = (st_q == ST_SEND) && (snd_q == '0);
    od_d = (st_q == ST_SEND) ? snd_byte : od_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q <= ST_IDLE; ret_q <= ST_IDLE; cnt_q <= '0; snd_q <= '0;
      tix_q <= '0; len_q <= '0; crc_q <= CRC32_INIT; last_q <= 1'b0;
      vpi_q <= '0; vci_q <= '0; uu_q <= '0;
      ov_q <= 1'b0; os_q <= 1'b0; od_q <= '0;
    end else begin
      st_q <= st_d; ret_q <= ret_d; cnt_q <= cnt_d; snd_q <= snd_d;
      tix_q <= tix_d; len_q <= len_d; crc_q <= crc_d; last_q <= last_d;
      vpi_q <= vpi_d; vci_q <= vci_d; uu_q <= uu_d;
      ov_q <= ov_d; os_q <= os_d; od_q <= od_d;
    end
  end

  assign in_ready       = rdy_w;
  assign out_valid      = ov_q;
  assign out_data       = od_q;
  assign out_cell_start = os_q;
endmodule

// File: rtl/aal5_seg_chk.sv
module aal5_seg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_cell_start
);
  // position of the current byte inside a cell, 0 when outside or at the start
  logic [5:0] pos_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pos_q <= '0;
    else if (out_cell_start)   pos_q <= 6'd1;
    else if (pos_q == 6'd52)   pos_q <= '0;
    else if (pos_q != '0)      pos_q <= pos_q + 1'b1;
  end

  p_cell_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q != '0) |-> (out_valid && !out_cell_start));

  p_no_stray_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cell_start || pos_q != '0));

  p_gfc_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_cell_start |-> (out_data[7:4] == 4'h0));

  p_clp_pti_hi_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == 6'd3) |-> ((out_data & 8'h0D) == 8'h00));

  p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !out_valid);
endmodule

bind aal5_seg aal5_seg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_data(out_data), .out_cell_start(out_cell_start)
);

// File: tb/tb_aal5_seg.sv
module tb_aal5_seg;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, in_valid, in_ready, in_sop, in_eop;
  logic [7:0]  in_data, in_vpi, in_uu, out_data;
  logic [15:0] in_vci;
  logic        out_valid, out_cell_start;

  aal5_seg dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_vpi(in_vpi),
    .in_vci(in_vci), .in_uu(in_uu), .out_valid(out_valid),
    .out_data(out_data), .out_cell_start(out_cell_start)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] exp_q[$];
  bit         sflag_q[$];
  string      tag_q[$];
  int vectors = 0, fails = 0, starts_seen = 0;
  bit busy = 0, mon_on = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc32(input logic [7:0] q[$]);
    logic [31:0] r = 32'hFFFF_FFFF;
    foreach (q[k]) begin
      r = r ^ {q[k], 24'h0};
      repeat (8) r = r[31] ? ((r << 1) ^ 32'h04C1_1DB7) : (r << 1);
    end
    return ~r;
  endfunction

  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [7:0] r = 8'h00;
    for (int b = 3; b >= 0; b--) begin
      r = r ^ h[8*b +: 8];
      repeat (8) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    end
    return r ^ 8'h55;
  endfunction

  function automatic logic [7:0] dbyte(input int i, input int seed);
    return 8'(i * 13 + seed * 7 + (i >> 3));
  endfunction

  // expected cell stream for one packet; returns the cell count
  function automatic int build(input int len, input logic [7:0] vpi,
                               input logic [15:0] vci, input logic [7:0] uu,
                               input int seed);
    logic [7:0] pdu[$];
    string      ptag[$];
    logic [7:0] snap[8] = '{8'hAA, 8'hAA, 8'h03, 8'h00, 8'h00, 8'h00, 8'h08, 8'h00};
    logic [31:0] crc, hdr;
    logic [15:0] flen;
    int npad, ncell;
    foreach (snap[k]) begin pdu.push_back(snap[k]); ptag.push_back("R1"); end
    for (int i = 0; i < len; i++) begin pdu.push_back(dbyte(i, seed)); ptag.push_back("R1"); end
    npad = (48 - ((len + 16) % 48)) % 48;
    repeat (npad) begin pdu.push_back(8'h00); ptag.push_back("R6"); end
    flen = 16'(len + 8);
    pdu.push_back(uu);          ptag.push_back("R7 R12");
    pdu.push_back(8'h00);       ptag.push_back("R7");
    pdu.push_back(flen[15:8]);  ptag.push_back("R7");
    pdu.push_back(flen[7:0]);   ptag.push_back("R7");
    crc = ref_crc32(pdu);
    for (int b = 3; b >= 0; b--) begin pdu.push_back(crc[8*b +: 8]); ptag.push_back("R8"); end
    ncell = pdu.size() / 48;
    for (int c = 0; c < ncell; c++) begin
      hdr = {4'h0, vpi, vci, 2'b00, (c == ncell - 1), 1'b0};
      exp_q.push_back(hdr[31:24]); sflag_q.push_back(1'b1); tag_q.push_back("R3 R12");
      exp_q.push_back(hdr[23:16]); sflag_q.push_back(1'b0); tag_q.push_back("R3 R12");
      exp_q.push_back(hdr[15:8]);  sflag_q.push_back(1'b0); tag_q.push_back("R3 R12");
      exp_q.push_back(hdr[7:0]);   sflag_q.push_back(1'b0); tag_q.push_back("R4");
      exp_q.push_back(ref_hec(hdr)); sflag_q.push_back(1'b0); tag_q.push_back("R5");
      for (int k = 0; k < 48; k++) begin
        exp_q.push_back(pdu[48*c + k]); sflag_q.push_back(1'b0);
        tag_q.push_back(ptag[48*c + k]);
      end
    end
    return ncell;
  endfunction

  // per-clock comparison against the reference stream
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "byte with nothing expected", out_data, 0);
        end else begin
          logic [7:0] e;
          bit s;
          string t;
          e = exp_q.pop_front(); s = sflag_q.pop_front(); t = tag_q.pop_front();
          check(out_data == e, t, "cell byte", out_data, e);
          check(out_cell_start == s, "R2", "cell start flag", out_cell_start, s);
          if (out_cell_start) starts_seen++;
          if (busy && exp_q.size() > 0)
            check(!in_ready, "R9", "ready during emission", in_ready, 0);
        end
      end else if (busy && exp_q.size() > 0) begin
        check(!in_ready, "R9", "ready during pad/trailer", in_ready, 0);
      end
    end
  end

  task automatic send_pkt(input int len, input logic [7:0] vpi,
                          input logic [15:0] vci, input logic [7:0] uu,
                          input int seed, input bit gaps);
    int i = 0, cyc = 0, ncell, s0;
    bit first = 1, acc;
    ncell = build(len, vpi, vci, uu, seed);
    s0 = starts_seen;
    while (i < len) begin
      @(negedge clk);
      cyc++;
      if (gaps && i > 0 && (cyc % 4 == 1)) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
        continue;
      end
      in_valid = 1'b1; in_data = dbyte(i, seed);
      in_sop = (i == 0); in_eop = (i == len - 1);
      if (first) begin in_vpi = vpi; in_vci = vci; in_uu = uu; end
      #1; acc = in_ready;
      @(posedge clk); #1;
      if (first) begin
        first = 0;
        in_vpi = ~vpi; in_vci = ~vci; in_uu = ~uu;
      end
      if (acc) i++;
    end
    busy = 1'b1;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    @(negedge clk);
    busy = 1'b0;
    check(starts_seen - s0 == ncell, "R6", $sformatf("cell count len=%0d", len),
          starts_seen - s0, ncell);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    in_data = '0; in_vpi = '0; in_vci = '0; in_uu = '0;
    repeat (3) @(negedge clk);
    check(!out_valid, "R11", "out_valid in reset", out_valid, 0);
    check(!out_cell_start, "R11", "cell start in reset", out_cell_start, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!out_valid, "R11", "out_valid after reset", out_valid, 0);
    mon_on = 1'b1;

    // R10: stray bytes while idle
    in_valid = 1'b1; in_data = 8'h5A; in_sop = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #1;
      check(in_ready, "R10", "stray byte accepted", in_ready, 1);
      @(negedge clk);
      check(!out_valid, "R10", "no output from stray byte", out_valid, 0);
    end
    in_valid = 1'b0;
    repeat (3) @(negedge clk);

    send_pkt(20,   8'h12, 16'h3456, 8'h9C, 1, 0);
    send_pkt(32,   8'hFE, 16'h0001, 8'h00, 2, 0);
    send_pkt(33,   8'h01, 16'hFFFF, 8'hA5, 3, 1);
    send_pkt(40,   8'h80, 16'h8000, 8'h7E, 4, 0);
    send_pkt(46,   8'h3C, 16'h1234, 8'h11, 5, 1);
    send_pkt(80,   8'h00, 16'h0020, 8'hFF, 6, 0);
    send_pkt(81,   8'h55, 16'hAAAA, 8'h42, 7, 0);
    send_pkt(1,    8'h0F, 16'hF0F0, 8'h01, 8, 0);
    send_pkt(128,  8'h99, 16'h0BAD, 8'h33, 9, 1);
    send_pkt(1500, 8'h47, 16'h0102, 8'hC3, 10, 0);

    check(exp_q.size() == 0, "R2", "leftover expected bytes", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule